// File: doc/BRIEF.md
# BCD Real-Time Clock Counter

This block keeps wall-clock time as six bytes that advance on a 256 Hz tick enable. The lowest byte is a plain binary fraction of a second. The five bytes above it are BCD fields: seconds, minutes, hours, and a four-digit day count split across two bytes. Software reaches the block through a byte-wide register port, which uses a valid/ready request channel and a one-cycle read response.

Setting the time is a two-step operation. Writes to the five upper bytes only fill a staging copy. A write to the sub-second byte stores that byte and then arms a load. The whole staged copy replaces the running count on the second tick after the write. While the load is armed, `busy` is high and the port holds `req_ready` low. A request that arrives during this window stays pending until `busy` clears, so the load window applies back-pressure.

Reading is also two-step. A read of the sub-second byte returns the live value and freezes all six running bytes into a snapshot. Reads of the upper bytes return that snapshot, so a read sequence that starts with the sub-second byte gives one coherent time. The read response is a single-cycle `rsp_valid` pulse with no back-pressure, because the block never holds more than one response.

Top module: `rtc_counter`

## Requirements
- R1: On each cycle with `tick` high, the sub-second byte (address 0) increments by one in binary. It wraps from 0xFF to 0x00, and that wrap is the carry into seconds.
- R2: Seconds (address 1) and minutes (address 2) count in BCD from 0x00 to 0x59 and then wrap to 0x00 with a carry. A write to either byte keeps only bits [6:0], so bit 7 always reads as 0.
- R3: Hours (address 3) count in BCD from 0x00 to 0x23, then wrap with a carry into the day count. A write to hours keeps only bits [5:0].
- R4: The day count is two BCD bytes, the low two digits at address 4 and the high two digits at address 5. It runs from 0000 to 9999 and then wraps to 0000.
- R5: A write to addresses 1 to 5 changes only the staging copy. The running time is unchanged until a load commits.
- R6: An accepted write to address 0 stages that byte and raises `busy` on the next cycle. The first tick after the write still increments the count. On the second tick, all six staged bytes replace the running count, and `busy` falls at that same edge.
- R7: While `busy` is high, `req_ready` is low and no request is accepted. A request held during this window has no effect on the staging copy and produces no response.
- R8: A read of address 0 returns the live sub-second byte and snapshots all six running bytes. A read of addresses 1 to 5 returns the snapshot, not the live count.
- R9: Each accepted read produces exactly one `rsp_valid` pulse, with its data in `rsp_data`, in the cycle after acceptance. Writes produce no response.
- R10: After reset, all running, staged and snapshot bytes are 0x00 and `busy` is low.
- R11: Addresses 6 and 7 are unused. Writes to them are ignored and reads of them return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 256 Hz count enable, one cycle wide |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Byte address (0 sub-second to 5 day-high) |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid, single-cycle pulse |
| rsp_data | output | 8 | Read data |
| busy | output | 1 | Staged load pending |

## Verification
The directed cases go after the edges of the carry chain. One case loads 9999 days, 23:59:59 and sub-second 0xFE, then ticks twice so every field wraps to zero on a single tick. A design with a wrong limit or a broken carry link would leave one field at 60, 24 or 10000, or would fail to clear it. Other cases check that bit 7 of seconds is dropped on a write, that upper-byte writes do not reach the running count before a commit, and that the snapshot stays frozen while the live count moves on. A design that read live data would return a newer seconds value here.

A design that committed on the first tick, or that skipped the increment on that tick, would show a sub-second value one step off after the load. A design that accepted requests while busy would corrupt the staging copy or emit a stray response. The random phase mixes ticks, reads and writes at all eight addresses against the bench model. It is run from a fixed seed.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 3;
  localparam int N_BYTES = 6;            // sub-second plus five BCD fields
  localparam int N_BCD   = N_BYTES - 1;

  typedef logic [BYTE_W-1:0] byte_t;

  localparam logic [ADDR_W-1:0] ADDR_SUB = 3'd0;

  // Last BCD value of field idx (0 = seconds) before it wraps
  function automatic byte_t bcd_limit(input int idx);
    case (idx)
      0, 1:    return 8'h59;
      2:       return 8'h23;
      default: return 8'h99;
    endcase
  endfunction

  // Bits kept on a write to byte idx (0 = sub-second)
  function automatic byte_t byte_mask(input int idx);
    case (idx)
      1, 2:    return 8'h7F;
      3:       return 8'h3F;
      default: return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtc_pkg::*;
#(
  parameter byte_t LIMIT = 8'h59
) (
  input  byte_t cur,
  input  logic  cin,
  output byte_t nxt
);
  always_comb begin
    nxt = cur;
    if (cin) begin
      if (cur == LIMIT)          nxt = 8'h00;
      else if (cur[3:0] >= 4'd9) nxt = {cur[7:4] + 4'd1, 4'd0};
      else                       nxt = {cur[7:4], cur[3:0] + 4'd1};
    end
  end
endmodule

// File: rtl/rtc_load_ctrl.sv
module rtc_load_ctrl #(
  parameter int COMMIT_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  output logic busy,
  output logic commit
);
  localparam int CW = (COMMIT_TICKS > 1) ? $clog2(COMMIT_TICKS) : 1;

  logic          pend_q;
  logic [CW-1:0] cnt_q;
  logic          last;

  assign last   = (cnt_q == CW'(COMMIT_TICKS - 1));
  assign commit = pend_q && tick && last;
  assign busy   = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      pend_q <= 1'b1;
      cnt_q  <= '0;
    end else if (pend_q && tick) begin
      if (last) pend_q <= 1'b0;
      else      cnt_q  <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/rtc_reg_port.sv
module rtc_reg_port
  import rtc_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      busy,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_we,
  input  logic [ADDR_W-1:0]         req_addr,
  input  byte_t                     req_wdata,
  input  logic [N_BYTES-1:0][BYTE_W-1:0] run_bytes,
  output logic [N_BYTES-1:0][BYTE_W-1:0] stage_bytes,
  output logic                      load_start,
  output logic                      rsp_valid,
  output byte_t                     rsp_data
);
  logic fire, wr, rd;
  logic [N_BYTES-1:0][BYTE_W-1:0] shadow_q;

  assign req_ready  = !busy;
  assign fire       = req_valid && req_ready;
  assign wr         = fire && req_we;
  assign rd         = fire && !req_we;
  assign load_start = wr && (req_addr == ADDR_SUB);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_bytes <= '0;
    end else if (wr) begin
      for (int i = 0; i < N_BYTES; i++)
        if (req_addr == ADDR_W'(i)) stage_bytes[i] <= req_wdata & byte_mask(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q  <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) begin
        if (req_addr == ADDR_SUB) begin
          shadow_q <= run_bytes;
          rsp_data <= run_bytes[0];
        end else if (req_addr < ADDR_W'(N_BYTES)) begin
          rsp_data <= shadow_q[req_addr];
        end else begin
          rsp_data <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
  import rtc_pkg::*;
#(
  parameter int COMMIT_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_data,
  output logic              busy
);
  logic [N_BYTES-1:0][BYTE_W-1:0] run_q, run_nxt, stage_q;
  logic [N_BCD-1:0] carry;
  logic load_start, commit;

  assign run_nxt[0] = run_q[0] + 8'd1;
  assign carry[0]   = (run_q[0] == 8'hFF);

  for (genvar gi = 0; gi < N_BCD; gi++) begin : g_field
    rtc_bcd_field #(.LIMIT(bcd_limit(gi))) u_field (
      .cur (run_q[gi+1]),
      .cin (carry[gi]),
      .nxt (run_nxt[gi+1])
    );
    if (gi < N_BCD - 1) begin : g_link
      assign carry[gi+1] = carry[gi] && (run_q[gi+1] == bcd_limit(gi));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      run_q <= '0;
    else if (commit) run_q <= stage_q;
    else if (tick)   run_q <= run_nxt;
  end

  rtc_load_ctrl #(.COMMIT_TICKS(COMMIT_TICKS)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .start  (load_start),
    .busy   (busy),
    .commit (commit)
  );

  rtc_reg_port u_port (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_we      (req_we),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .run_bytes   (run_q),
    .stage_bytes (stage_q),
    .load_start  (load_start),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data)
  );
endmodule

// File: rtl/rtc_counter_chk.sv
module rtc_counter_chk
  import rtc_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic busy,
  input logic req_valid,
  input logic req_ready,
  input logic req_we,
  input logic [ADDR_W-1:0] req_addr,
  input logic rsp_valid,
  input logic [N_BYTES-1:0][BYTE_W-1:0] run_q
);
  AST_SUB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !busy) |=> run_q[0] == $past(run_q[0]) + 8'd1); // R1
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !busy && run_q[0] == 8'hFF && run_q[1] == 8'h59) |=> run_q[1] == 8'h00); // R2
  AST_HOUR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !busy && run_q[0] == 8'hFF && run_q[1] == 8'h59 && run_q[2] == 8'h59
     && run_q[3] == 8'h23) |=> run_q[3] == 8'h00); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(run_q)); // R5
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid && req_ready && req_we && req_addr == ADDR_SUB)); // R6
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tick)); // R6
  AST_NO_RSP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && busy) |=> !rsp_valid); // R7
  AST_RSP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && !req_we)); // R9
endmodule

bind rtc_counter rtc_counter_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .busy      (busy),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_we    (req_we),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .run_q     (run_q)
);

// File: tb/rtc_counter_test.sv
`timescale 1ns/1ps
module rtc_counter_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, tick = 1'b0, req_valid = 1'b0, req_we = 1'b0;
  logic [2:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid, busy;
  logic [7:0] rsp_data;

  rtc_counter uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req_valid(req_valid),
    .req_ready(req_ready), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  int m_sub, m_sec, m_min, m_hr, m_day, m_tcnt;
  bit m_pend;
  logic [7:0] m_stage[6];
  logic [7:0] m_shadow[6];

  function automatic logic [7:0] bcd(int v); return 8'((v / 10) * 16 + v % 10); endfunction
  function automatic int unbcd(logic [7:0] b); return int'(b[7:4]) * 10 + int'(b[3:0]); endfunction
  function automatic logic [7:0] wmask(int i);
    return (i == 1 || i == 2) ? 8'h7F : (i == 3) ? 8'h3F : 8'hFF;
  endfunction
  function automatic logic [7:0] m_byte(int i);
    case (i)
      0: return 8'(m_sub);
      1: return bcd(m_sec);
      2: return bcd(m_min);
      3: return bcd(m_hr);
      4: return bcd(m_day % 100);
      default: return bcd(m_day / 100);
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic m_incr();
    m_sub++;
    if (m_sub == 256) begin
      m_sub = 0; m_sec++;
      if (m_sec == 60) begin
        m_sec = 0; m_min++;
        if (m_min == 60) begin
          m_min = 0; m_hr++;
          if (m_hr == 24) begin
            m_hr = 0; m_day++;
            if (m_day == 10000) m_day = 0;
          end
        end
      end
    end
  endtask

  // One clock cycle: drive at negedge, update model at the edge, check at next negedge
  task automatic step(bit t, bit v, bit we, logic [2:0] a, logic [7:0] d, string tag);
    bit acc, commit, start;
    logic [7:0] exp;
    tick = t; req_valid = v; req_we = we; req_addr = a; req_wdata = d;
    chk(req_ready == !m_pend, "R7 ready", int'(req_ready), int'(!m_pend));
    acc = v && !m_pend;
    exp = 8'h00;
    @(posedge clk);
    commit = m_pend && t && (m_tcnt == 1);
    start  = acc && we && (a == 3'd0);
    if (acc && !we) begin
      if (a == 3'd0) begin
        exp = m_byte(0);
        for (int i = 0; i < 6; i++) m_shadow[i] = m_byte(i);
      end else if (a < 3'd6) exp = m_shadow[a];
    end
    if (commit) begin
      m_sub = int'(m_stage[0]); m_sec = unbcd(m_stage[1]); m_min = unbcd(m_stage[2]);
      m_hr = unbcd(m_stage[3]); m_day = unbcd(m_stage[4]) + 100 * unbcd(m_stage[5]);
    end else if (t) m_incr();
    if (acc && we && a < 3'd6) m_stage[a] = d & wmask(int'(a));
    if (start) begin m_pend = 1; m_tcnt = 0; end
    else if (m_pend && t) begin
      if (m_tcnt == 1) m_pend = 0; else m_tcnt++;
    end
    @(negedge clk);
    chk(busy == m_pend, "R6 busy", int'(busy), int'(m_pend));
    if (acc && !we) begin
      chk(rsp_valid == 1'b1, "R9 rsp_valid", int'(rsp_valid), 1);
      chk(rsp_data == exp, tag, int'(rsp_data), int'(exp));
    end else
      chk(rsp_valid == 1'b0, "R9 no rsp", int'(rsp_valid), 0);
    tick = 0; req_valid = 0;
  endtask

  task automatic read_all(string tag);
    for (int i = 0; i < 6; i++) step(0, 1, 0, 3'(i), 8'h00, tag);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, 3'd0, 8'h00, "R1");
  endtask

  // Stage five upper bytes then sub-second, commit with two ticks
  task automatic load(logic [7:0] s, logic [7:0] sec, logic [7:0] mn, logic [7:0] hr,
                      logic [7:0] dl, logic [7:0] dh);
    step(0, 1, 1, 3'd1, sec, "R5"); step(0, 1, 1, 3'd2, mn, "R5");
    step(0, 1, 1, 3'd3, hr, "R5");  step(0, 1, 1, 3'd4, dl, "R5");
    step(0, 1, 1, 3'd5, dh, "R5");  step(0, 1, 1, 3'd0, s, "R6");
    step(1, 0, 0, 3'd0, 8'h00, "R6"); step(1, 0, 0, 3'd0, 8'h00, "R6");
  endtask

  function automatic logic [7:0] rnd_data(logic [2:0] a);
    case (a)
      3'd1, 3'd2: return bcd(int'($urandom % 60));
      3'd3:       return bcd(int'($urandom % 24));
      3'd4, 3'd5: return bcd(int'($urandom % 100));
      default:    return 8'($urandom);
    endcase
  endfunction

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_sub = 0; m_sec = 0; m_min = 0; m_hr = 0; m_day = 0; m_tcnt = 0; m_pend = 0;
    for (int i = 0; i < 6; i++) begin m_stage[i] = 0; m_shadow[i] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(busy == 1'b0, "R10 busy", int'(busy), 0);
    read_all("R10 reset read");
    // R1 binary sub-second count
    ticks(3);
    step(0, 1, 0, 3'd0, 8'h00, "R1 sub count");
    // R5 staged writes leave running time alone
    step(0, 1, 1, 3'd1, 8'h42, "R5"); step(0, 1, 1, 3'd3, 8'h11, "R5");
    ticks(2);
    read_all("R5 staged only");
    // R2 mask bit7, full wrap across every field (R4)
    load(8'hFE, 8'hD9, 8'h59, 8'h23, 8'h99, 8'h99);
    read_all("R2 R6 loaded");
    ticks(2);
    read_all("R4 day wrap");
    // R3 hour carry without day wrap
    load(8'hFF, 8'h59, 8'h59, 8'h22, 8'h07, 8'h00);
    ticks(1);
    read_all("R3 hour step");
    load(8'hFF, 8'h59, 8'h59, 8'h23, 8'h99, 8'h12);
    ticks(1);
    read_all("R3 day carry");
    // R7 requests held while busy are not accepted
    step(0, 1, 1, 3'd0, 8'h10, "R6");
    step(0, 1, 1, 3'd1, 8'h33, "R7"); step(0, 1, 0, 3'd1, 8'h00, "R7");
    step(1, 1, 1, 3'd2, 8'h44, "R7"); step(1, 1, 0, 3'd0, 8'h00, "R7");
    read_all("R7 after busy");
    // R8 snapshot stays frozen while live count moves
    load(8'hFF, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00);
    step(0, 1, 0, 3'd0, 8'h00, "R8 sub");
    ticks(2);
    step(0, 1, 0, 3'd1, 8'h00, "R8 frozen sec");
    // R11 unused addresses
    step(0, 1, 1, 3'd7, 8'hAA, "R11"); step(0, 1, 1, 3'd6, 8'h55, "R11");
    step(0, 1, 0, 3'd6, 8'h00, "R11 read6"); step(0, 1, 0, 3'd7, 8'h00, "R11 read7");
    read_all("R11 no side effect");
    // Random mix
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] a;
      a = 3'($urandom % 8);
      step(($urandom % 4) == 0, ($urandom % 3) == 0, ($urandom % 2) == 0, a,
           rnd_data(a), "R8 random read");
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule